// File: doc/BRIEF.md
# Trigger-Latency Pipeline with Accept Capture

This block delays every bunch crossing's multi-link data word by a run-time programmable number of clock cycles, so that the word leaves the delay line just as the level-1 accept decision for that crossing arrives. Each clock cycle carries one crossing. Three 16-bit link words travel side by side as one 48-bit word. When the accept pulse is seen, the word leaving the delay line in that cycle is appended to a 256-entry DAQ FIFO.

A readout port drains the FIFO one crossing at a time. A start pulse moves the oldest entry into a frame holder and raises a per-link valid pattern. The external readout logic then collects the frame one 16-bit word per request: the valid-pattern word comes first, then the link words in ascending link order.

Control and status use a small 16-bit register bus with two addresses. Address 0 holds the programmed delay and the delay-line flags and accepts a flush command. Address 1 reports the FIFO fill state and a sticky overflow flag.

Top module: `l1_latency_capture`

## Requirements
- R1: After reset, lat_ok is low, ro_ack is low, ro_vpat is zero, address 0 reads 0x4004 (empty, delay 4) and address 1 reads 0x4000 (FIFO empty).
- R2: With active delay D (1 to 511), lat_data after clock edge k equals the xing_data sampled at edge k−D. lat_ok goes high at the D-th edge counted from the first edge after a flush or after reset release. A programmed delay of 0 behaves as 1.
- R3: A bus write to address 0 stores bits 8:0 as the programmed delay, which reads back at once. The active delay changes only when a write to address 0 carries bit 12 set (flush), and it then takes the delay value written in that same access.
- R4: A flush discards the delay-line contents: lat_ok is low after the flush edge and refills as in R2.
- R5: Address 0 reads bit 15 = delay-line output valid (full), bit 14 = nothing stored since the last flush or reset (empty), bits 8:0 = programmed delay, and all other bits 0.
- R6: An l1a high in a cycle with lat_ok high appends the lat_data present in that cycle to the FIFO. An l1a while lat_ok is low leaves the FIFO unchanged.
- R7: Address 1 reads bits 7:0 = entry count modulo 256, bit 15 = full (256 entries), bit 14 = empty, bit 13 = overflow, and all other bits 0.
- R8: An l1a that would capture while the FIFO is full is dropped and sets the overflow bit. The bit stays set until a write to address 1 with bit 13 set.
- R9: ro_start while no frame is open and the FIFO is not empty removes the oldest entry. From the next cycle, ro_vpat bit i is 1 exactly when link i's word (bits 16i+15:16i) is nonzero. A start while the FIFO is empty or a frame is open is ignored.
- R10: During an open frame, each cycle with ro_req high produces ro_ack high in the next cycle with ro_data set to the valid pattern (zero-extended), then link 0, link 1, link 2. After the last word the frame closes and ro_vpat returns to zero. ro_ack is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossing per cycle |
| rst | input | 1 | Synchronous active-high reset |
| xing_data | input | 48 | Crossing word, link i in bits 16i+15:16i |
| l1a | input | 1 | Level-1 accept pulse |
| lat_data | output | 48 | Delayed crossing word |
| lat_ok | output | 1 | lat_data holds a crossing stored since the last flush |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 1 | 0 = delay line, 1 = DAQ FIFO |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| ro_start | input | 1 | Open a readout frame |
| ro_req | input | 1 | Request one readout word |
| ro_ack | output | 1 | Word on ro_data is valid |
| ro_data | output | 16 | Readout word |
| ro_vpat | output | 3 | Per-link valid pattern of the open frame |

## Verification
The bench builds the block with its defaults: three links of 16 bits, a 512-entry delay line and a 256-entry FIFO. These values let a run reach the longest delay of 511 and a completely full FIFO followed by overflow. Random crossings with frequently zero link words exercise every valid-pattern combination. Directed phases cover a delay change held back until a flush, the delay value 0, accepts during refill, a second start during an open frame, and a start on an empty FIFO.

// File: rtl/l1cap_pkg.sv
package l1cap_pkg;

    localparam int REG_W     = 16;
    localparam logic ADDR_PIPE = 1'b0;
    localparam logic ADDR_DAQ  = 1'b1;
    localparam int BIT_FLUSH = 12;
    localparam int BIT_OVF   = 13;

    typedef struct packed {
        logic        full;
        logic        empty;
        logic        ovf;
        logic        rsv;
        logic [11:0] field;
    } stat_word_t;

    typedef enum logic [1:0] {
        RO_IDLE,
        RO_PATTERN,
        RO_LINKS
    } ro_phase_e;

    function automatic logic [REG_W-1:0] pack_status(
        input logic full, input logic empty, input logic ovf, input logic [11:0] field);
        stat_word_t s;
        s.full  = full;
        s.empty = empty;
        s.ovf   = ovf;
        s.rsv   = 1'b0;
        s.field = field;
        return s;
    endfunction

endpackage

// File: rtl/l1cap_pipe.sv
module l1cap_pipe #(
    parameter int DW = 48,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [AW-1:0] delay,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_ok,
    output logic          is_empty
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] raddr;
    logic [AW-1:0] fill;

    assign raddr    = wptr - delay;
    assign is_empty = (fill == '0);

    always_ff @(posedge clk) begin
        mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            fill    <= '0;
            dout_ok <= 1'b0;
            dout    <= '0;
        end else begin
            wptr <= wptr + 1'b1;
            dout <= mem[raddr];
            if (flush) begin
                fill    <= '0;
                dout_ok <= 1'b0;
            end else begin
                if (fill != {AW{1'b1}})
                    fill <= fill + 1'b1;
                dout_ok <= (fill >= delay);
            end
        end
    end

endmodule

// File: rtl/l1cap_fifo.sv
module l1cap_fifo #(
    parameter int DW = 48,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/l1cap_readout.sv
module l1cap_readout
    import l1cap_pkg::*;
#(
    parameter int LINKS = 3,
    parameter int LW    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                req,
    input  logic                fifo_empty,
    input  logic [LINKS*LW-1:0] head,
    output logic                pop,
    output logic                ack,
    output logic [LW-1:0]       data,
    output logic [LINKS-1:0]    vpat
);
    localparam int IW = $clog2(LINKS + 1);

    ro_phase_e           phase;
    logic [LINKS*LW-1:0] frame;
    logic [IW-1:0]       idx;
    logic [LINKS-1:0]    head_bits;

    for (genvar g = 0; g < LINKS; g++) begin : g_vbit
        assign head_bits[g] = |head[g*LW +: LW];
    end

    assign pop = (phase == RO_IDLE) && start && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= RO_IDLE;
            frame <= '0;
            idx   <= '0;
            vpat  <= '0;
            ack   <= 1'b0;
            data  <= '0;
        end else begin
            ack <= 1'b0;
            case (phase)
                RO_IDLE: begin
                    if (pop) begin
                        frame <= head;
                        vpat  <= head_bits;
                        phase <= RO_PATTERN;
                    end
                end
                RO_PATTERN: begin
                    if (req) begin
                        ack   <= 1'b1;
                        data  <= LW'(vpat);
                        idx   <= '0;
                        phase <= RO_LINKS;
                    end
                end
                RO_LINKS: begin
                    if (req) begin
                        ack  <= 1'b1;
                        data <= frame[idx*LW +: LW];
                        idx  <= idx + 1'b1;
                        if (idx == IW'(LINKS - 1)) begin
                            phase <= RO_IDLE;
                            vpat  <= '0;
                        end
                    end
                end
                default: phase <= RO_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/l1_latency_capture.sv
module l1_latency_capture
    import l1cap_pkg::*;
#(
    parameter int LINKS       = 3,
    parameter int LW          = 16,
    parameter int PIPE_AW     = 9,
    parameter int DAQ_AW      = 8,
    parameter int RESET_DELAY = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LINKS*LW-1:0] xing_data,
    input  logic                l1a,
    output logic [LINKS*LW-1:0] lat_data,
    output logic                lat_ok,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic                ro_start,
    input  logic                ro_req,
    output logic                ro_ack,
    output logic [LW-1:0]       ro_data,
    output logic [LINKS-1:0]    ro_vpat
);
    localparam int DW = LINKS * LW;

    logic               wr_pipe, wr_daq, flush_cmd;
    logic [PIPE_AW-1:0] pend_delay, act_delay, pend_nxt;
    logic               pipe_empty;
    logic               ovf, ovf_set, ovf_clr;
    logic [DW-1:0]      fifo_head;
    logic [DAQ_AW:0]    daq_cnt;
    logic               daq_full, daq_empty, fifo_pop;
    logic               unused_wbits;

    assign wr_pipe   = bus_sel && bus_wr && (bus_addr == ADDR_PIPE);
    assign wr_daq    = bus_sel && bus_wr && (bus_addr == ADDR_DAQ);
    assign flush_cmd = wr_pipe && bus_wdata[BIT_FLUSH];
    assign pend_nxt  = wr_pipe ? bus_wdata[PIPE_AW-1:0] : pend_delay;
    assign ovf_set   = l1a && lat_ok && daq_full;
    assign ovf_clr   = wr_daq && bus_wdata[BIT_OVF];
    assign unused_wbits = ^{bus_wdata[REG_W-1:BIT_OVF+1], bus_wdata[BIT_FLUSH-1:PIPE_AW]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_delay <= PIPE_AW'(RESET_DELAY);
            act_delay  <= PIPE_AW'(RESET_DELAY);
            ovf        <= 1'b0;
        end else begin
            pend_delay <= pend_nxt;
            if (flush_cmd)
                act_delay <= (pend_nxt == '0) ? PIPE_AW'(1) : pend_nxt;
            if (ovf_set)
                ovf <= 1'b1;
            else if (ovf_clr)
                ovf <= 1'b0;
        end
    end

    l1cap_pipe #(.DW(DW), .AW(PIPE_AW)) i_pipe (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush_cmd),
        .delay    (act_delay),
        .din      (xing_data),
        .dout     (lat_data),
        .dout_ok  (lat_ok),
        .is_empty (pipe_empty)
    );

    l1cap_fifo #(.DW(DW), .AW(DAQ_AW)) i_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (l1a && lat_ok),
        .din   (lat_data),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .count (daq_cnt),
        .full  (daq_full),
        .empty (daq_empty)
    );

    l1cap_readout #(.LINKS(LINKS), .LW(LW)) i_readout (
        .clk        (clk),
        .rst        (rst),
        .start      (ro_start),
        .req        (ro_req),
        .fifo_empty (daq_empty),
        .head       (fifo_head),
        .pop        (fifo_pop),
        .ack        (ro_ack),
        .data       (ro_data),
        .vpat       (ro_vpat)
    );

    always_comb begin
        if (bus_addr == ADDR_PIPE)
            bus_rdata = pack_status(lat_ok, pipe_empty, 1'b0, 12'(pend_delay));
        else
            bus_rdata = pack_status(daq_full, daq_empty, ovf, 12'(daq_cnt[DAQ_AW-1:0]));
    end

endmodule

// File: rtl/l1cap_checker.sv
module l1cap_checker #(
    parameter int CNT_W    = 9,
    parameter int FULL_CNT = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             l1a,
    input logic             lat_ok,
    input logic             ro_req,
    input logic             ro_ack,
    input logic             flush_cmd,
    input logic             ovf,
    input logic             ovf_clr,
    input logic             fifo_pop,
    input logic [CNT_W-1:0] daq_cnt
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        daq_cnt <= CNT_W'(FULL_CNT)); // R7

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        ro_ack |-> $past(ro_req)); // R10

    AST_FLUSH_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        flush_cmd |=> !lat_ok); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf); // R8

    AST_FULL_DISCARDS: assert property (@(posedge clk) disable iff (rst)
        (l1a && lat_ok && daq_cnt == CNT_W'(FULL_CNT) && !fifo_pop) |=> daq_cnt == CNT_W'(FULL_CNT)); // R8

    AST_NO_CAPTURE_INVALID: assert property (@(posedge clk) disable iff (rst)
        ((!l1a || !lat_ok) && !fifo_pop) |=> daq_cnt == $past(daq_cnt)); // R6

endmodule

bind l1_latency_capture l1cap_checker #(
    .CNT_W    (DAQ_AW + 1),
    .FULL_CNT (1 << DAQ_AW)
) i_l1cap_checker (
    .clk       (clk),
    .rst       (rst),
    .l1a       (l1a),
    .lat_ok    (lat_ok),
    .ro_req    (ro_req),
    .ro_ack    (ro_ack),
    .flush_cmd (flush_cmd),
    .ovf       (ovf),
    .ovf_clr   (ovf_clr),
    .fifo_pop  (fifo_pop),
    .daq_cnt   (daq_cnt)
);

// File: tb/test_l1_latency_capture.sv
module test_l1_latency_capture;

    localparam int CLK_PERIOD = 10;
    localparam int LINKS  = 3;
    localparam int LW     = 16;
    localparam int DW     = LINKS * LW;
    localparam int FDEPTH = 256;
    localparam int RST_D  = 4;
    localparam int HN     = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] xing_data = '0;
    logic          l1a = 1'b0;
    logic [DW-1:0] lat_data;
    logic          lat_ok;
    logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          ro_start = 1'b0, ro_req = 1'b0;
    logic          ro_ack;
    logic [15:0]   ro_data;
    logic [LINKS-1:0] ro_vpat;

    l1_latency_capture i_l1_latency_capture (
        .clk(clk), .rst(rst), .xing_data(xing_data), .l1a(l1a),
        .lat_data(lat_data), .lat_ok(lat_ok),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ro_start(ro_start), .ro_req(ro_req), .ro_ack(ro_ack),
        .ro_data(ro_data), .ro_vpat(ro_vpat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int ecnt = 0;
    always @(posedge clk) ecnt <= ecnt + 1;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [DW-1:0] hist [HN];
    logic [DW-1:0] q [$];
    int  fl = 0;
    int  dact = RST_D;
    int  pend = RST_D;
    bit  ovf_m = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ok_at(input int m);
        return m >= fl + 1 + dact;
    endfunction

    function automatic logic [DW-1:0] data_at(input int m);
        return hist[(m - dact) % HN];
    endfunction

    function automatic logic [DW-1:0] rand_xing();
        logic [DW-1:0] v = '0;
        for (int i = 0; i < LINKS; i++)
            v[i*LW +: LW] = ($urandom % 4 == 0) ? '0 : LW'($urandom);
        return v;
    endfunction

    function automatic logic [LINKS-1:0] vpat_of(input logic [DW-1:0] e);
        logic [LINKS-1:0] p;
        for (int i = 0; i < LINKS; i++) p[i] = |e[i*LW +: LW];
        return p;
    endfunction

    function automatic logic [15:0] pipe_exp();
        return {ok_at(ecnt - 1), (ecnt - 1 == fl), 5'b0, 9'(pend)};
    endfunction

    function automatic logic [15:0] daq_exp();
        int s = q.size();
        return {(s == FDEPTH), (s == 0), ovf_m, 5'b0, 8'(s)};
    endfunction

    // One clock edge: update the model for the edge, then wait to the next falling edge.
    task automatic tick();
        int n = ecnt;
        hist[n % HN] = xing_data;
        if (rst) begin
            fl = n; dact = RST_D; pend = RST_D; q.delete(); ovf_m = 1'b0;
        end else begin
            if (bus_sel && bus_wr && bus_addr && bus_wdata[13]) ovf_m = 1'b0;
            if (l1a && ok_at(n - 1)) begin
                if (q.size() == FDEPTH) ovf_m = 1'b1;
                else q.push_back(data_at(n - 1));
            end
            if (bus_sel && bus_wr && !bus_addr) begin
                pend = int'(bus_wdata[8:0]);
                if (bus_wdata[12]) begin
                    fl = n;
                    dact = (pend == 0) ? 1 : pend;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_lat();
        int m = ecnt - 1;
        chk("R2/R4 lat_ok", lat_ok, ok_at(m));
        if (ok_at(m)) chk("R2 lat_data delay", lat_data, data_at(m));
    endtask

    task automatic run(input int cycles, input int pct);
        for (int i = 0; i < cycles; i++) begin
            xing_data = rand_xing();
            l1a = (($urandom % 100) < pct);
            tick();
            check_lat();
        end
        l1a = 1'b0;
    endtask

    task automatic rd_check(input logic addr, input logic [15:0] exp, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        #1;
        chk(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic addr, input logic [15:0] val);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = val;
        xing_data = rand_xing();
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        check_lat();
    endtask

    task automatic readout(input bit dbl);
        int pre = q.size();
        logic [DW-1:0] e = (pre > 0) ? q[0] : '0;
        logic [LINKS-1:0] vp = (pre > 0) ? vpat_of(e) : '0;
        logic [15:0] w;
        ro_start = 1'b1; xing_data = rand_xing();
        tick();
        ro_start = 1'b0;
        if (pre > 0) void'(q.pop_front());
        chk("R9 valid pattern after start", ro_vpat, vp);
        if (pre == 0) begin
            ro_req = 1'b1;
            tick();
            chk("R9 start on empty gives no ack", ro_ack, 0);
            ro_req = 1'b0;
            return;
        end
        if (dbl) begin
            ro_start = 1'b1;
            tick();
            ro_start = 1'b0;
            rd_check(1'b1, daq_exp(), "R9 second start in open frame ignored");
        end
        for (int k = 0; k <= LINKS; k++) begin
            ro_req = 1'b1;
            tick();
            w = (k == 0) ? 16'(vp) : e[(k-1)*LW +: LW];
            chk("R10 ack per request", ro_ack, 1);
            chk("R10 word order", ro_data, w);
        end
        ro_req = 1'b0;
        chk("R10 pattern cleared after frame", ro_vpat, 0);
        tick();
        chk("R10 no ack without request", ro_ack, 0);
    endtask

    task automatic drain();
        int guard = 0;
        while (q.size() > 0 && guard < 400) begin
            readout(guard == 1);
            guard++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1a7c));
        @(negedge clk);
        for (int i = 0; i < 4; i++) tick();
        // R1 reset state
        chk("R1 lat_ok", lat_ok, 0);
        chk("R1 ro_ack", ro_ack, 0);
        chk("R1 ro_vpat", ro_vpat, 0);
        rd_check(1'b0, 16'h4004, "R1 delay-line status");
        rd_check(1'b1, 16'h4000, "R1 FIFO status");
        rst = 1'b0;

        run(60, 25);                               // R2 delay 4, R6 captures
        rd_check(1'b1, daq_exp(), "R7 count after random captures");
        drain();
        readout(1'b0);                             // R9 start on empty

        bus_write(1'b0, 16'h0009);                 // R3 held back
        rd_check(1'b0, pipe_exp(), "R3 programmed delay readback");
        run(20, 0);
        bus_write(1'b0, 16'h1009);                 // R3 flush applies 9
        rd_check(1'b0, pipe_exp(), "R4/R5 empty after flush");
        run(3, 100);                               // R6 accepts while refilling
        rd_check(1'b1, daq_exp(), "R6 accept ignored while not valid");
        run(30, 30);
        rd_check(1'b0, pipe_exp(), "R5 full flag with delay 9");
        drain();

        bus_write(1'b0, 16'h1000);                 // R2 delay 0 acts as 1
        run(20, 30);
        drain();

        bus_write(1'b0, 16'h11FF);                 // R2 maximum delay
        run(530, 5);
        rd_check(1'b0, pipe_exp(), "R5 status at delay 511");
        drain();

        bus_write(1'b0, 16'h1002);
        run(270, 100);                             // R7 full, R8 overflow
        rd_check(1'b1, daq_exp(), "R7/R8 full with overflow");
        chk("R7 model full", q.size(), FDEPTH);
        bus_write(1'b1, 16'h2000);                 // R8 clear
        rd_check(1'b1, daq_exp(), "R8 overflow cleared, still full");
        drain();
        rd_check(1'b1, daq_exp(), "R7 empty after drain");
        readout(1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule